// File: doc/BRIEF.md
# Triggered Multiplexed Analog Readout Sequencer

This block sequences the analog readout of several 32-channel front-end chips. Each chip presents a high-gain and a low-gain multiplexed analog output, and all of them feed one multi-lane 12-bit ADC. In compare mode a scan starts when any chip's fast-trigger line is high. The block counts a programmable delay in fine steps of one clock, then raises a hold line so the chips keep their shaper-peak voltages. After a fixed settling latency it steps a shared multiplexer address through all channels, one fixed-length slot per channel.

At a programmable sampling point inside each slot, the block captures every ADC lane at once. It then sends the captured words one by one on a valid/ready stream. Each word is tagged with its chip, channel and gain. In free-running mode no hold is raised and scans follow each other without any trigger, which suits baseline tracking. A busy flag covers the whole scan, and a new trigger is only accepted once busy has fallen.

Top module: `readout_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `hold`, `busy`, `out_valid` and `mux_addr` are all 0.
- R2: In compare mode (`free_run`=0), a high level on any single bit of `trig_in` while the block is idle starts a scan. `busy` is 1 from the clock edge that sees the trigger.
- R3: `hold` rises exactly `hold_dly`+1 clock cycles after the edge that accepted the trigger. One count of `hold_dly` is one clock period.
- R4: `SETTLE_CYCLES` cycles after `hold` rises, `mux_addr` starts at 0 and steps by one every `SLOT_CYCLES` cycles up to `N_CH`-1.
- R5: The ADC lanes are captured on the edge at slot offset `samp_pt`. Lane k sits at `adc_bus[k*12 +: 12]` and carries chip k/2, with k even meaning high gain and k odd meaning low gain. The lanes are sent in ascending k order, starting one cycle after the capture and one word per cycle while `out_ready` is 1.
- R6: Each sent word carries `out_chip` (0..N_CHIPS-1), `out_chan` (the channel whose slot it was captured in), `out_lowgain` (1 = low gain) and `out_data` (the captured value).
- R7: While `out_valid`=1 and `out_ready`=0, the word and its tags stay unchanged. If the previous channel's words are not all sent when the sampling point comes round, the slot waits there, so no channel's samples are ever lost.
- R8: Triggers that arrive while `busy` is 1 are ignored. They start neither a second hold pulse nor a second scan.
- R9: `busy` stays 1 until the last word of the scan has been accepted, and it falls on the next edge.
- R10: At the edge after the last channel slot, `hold` falls and `mux_addr` returns to 0.
- R11: In free-running mode `hold` stays 0, and scans repeat back to back without any trigger.
- R12: A `samp_pt` larger than `SLOT_CYCLES`-1 is treated as the last cycle of the slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one fine delay step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| free_run | input | 1 | 1 = free-running scans, 0 = triggered compare mode |
| trig_in | input | N_CHIPS | Per-chip OR32 fast-trigger lines |
| hold_dly | input | DLY_W | Delay from trigger to hold, in clock periods |
| samp_pt | input | SLOT_W | Sampling offset within each channel slot |
| adc_bus | input | 2*N_CHIPS*ADC_W | Parallel ADC lanes, lane k = 2*chip + low-gain flag |
| hold | output | 1 | Hold line to the front-end chips |
| mux_addr | output | CH_W | Shared analog multiplexer channel address |
| busy | output | 1 | Scan in progress |
| out_valid | output | 1 | Sample word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_chip | output | CHIP_W | Chip index of the word |
| out_chan | output | CH_W | Channel index of the word |
| out_lowgain | output | 1 | 1 = low-gain sample, 0 = high-gain |
| out_data | output | ADC_W | Captured ADC value |

## Verification
When the sampling point is the last cycle of a slot, the capture of the final channel lands on the same edge as the end of the scan, where `hold` falls and `mux_addr` returns to 0. The drain of those six words then has to keep `busy` high past the scan end. This is provoked with `samp_pt` set to the last slot cycle, and also to an out-of-range value that must clamp to it. A behavioural per-cycle model predicts `hold`, `mux_addr`, `busy`, `out_valid` and each payload, including `busy` staying high for six extra cycles, and is compared on every clock. Separately, random backpressure makes the sampling point collide with a buffer that is still full. There the stream content is checked word by word against the expected chip/channel/gain order.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_DELAY,
    SQ_SETTLE,
    SQ_SCAN,
    SQ_DRAIN
  } seq_state_e;

  // Width needed to hold an index below n (at least one bit).
  function automatic int bits_for(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rs_reset_sync.sv
module rs_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/rs_start_gate.sv
module rs_start_gate #(
  parameter int N_CHIPS = 3
) (
  input  logic [N_CHIPS-1:0] trig_lines,
  input  logic               free_sel,
  output logic               start_req
);

  logic any_trig;

  // OR of every chip's fast-trigger line
  always_comb begin
    any_trig = 1'b0;
    for (int k = 0; k < N_CHIPS; k++) begin
      any_trig = any_trig | trig_lines[k];
    end
  end

  assign start_req = free_sel | any_trig;

endmodule

// File: rtl/rs_sequencer.sv
module rs_sequencer
  import rs_pkg::*;
#(
  parameter int N_CH          = 32,
  parameter int SLOT_CYCLES   = 10,
  parameter int SETTLE_CYCLES = 4,
  parameter int DLY_W         = 8,
  localparam int CH_W   = bits_for(N_CH),
  localparam int SLOT_W = bits_for(SLOT_CYCLES),
  localparam int SETL_W = bits_for(SETTLE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              free_sel,
  input  logic [DLY_W-1:0]  hold_dly,
  input  logic [SLOT_W-1:0] samp_pt,
  input  logic              buf_pending,
  output logic              hold,
  output logic [CH_W-1:0]   mux_addr,
  output logic              busy,
  output logic              capture
);

  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOT_CYCLES - 1);
  localparam logic [CH_W-1:0]   LAST_CH    = CH_W'(N_CH - 1);
  localparam logic [SETL_W-1:0] SETL_START = SETL_W'(SETTLE_CYCLES - 1);

  seq_state_e        state_q, state_d;
  logic [DLY_W-1:0]  dly_q,   dly_d;
  logic [SETL_W-1:0] setl_q,  setl_d;
  logic [SLOT_W-1:0] slot_q,  slot_d;
  logic [CH_W-1:0]   ch_q,    ch_d;
  logic              hold_q,  hold_d;

  logic [SLOT_W-1:0] samp_eff;
  logic              at_samp;
  logic              stall;
  logic              run_en;

  // Clamp an out-of-range sampling point to the last slot cycle (R12)
  assign samp_eff = (samp_pt > LAST_SLOT) ? LAST_SLOT : samp_pt;
  assign at_samp  = (slot_q == samp_eff);
  assign stall    = at_samp && buf_pending;
  assign capture  = (state_q == SQ_SCAN) && at_samp && !buf_pending;
  assign run_en   = (state_q != SQ_IDLE) || start_req;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    setl_d  = setl_q;
    slot_d  = slot_q;
    ch_d    = ch_q;
    hold_d  = hold_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_req) begin
          if (free_sel) begin
            state_d = SQ_SETTLE;
            setl_d  = SETL_START;
          end else begin
            state_d = SQ_DELAY;
            dly_d   = hold_dly;
          end
        end
      end
      SQ_DELAY: begin
        if (dly_q == '0) begin
          state_d = SQ_SETTLE;
          setl_d  = SETL_START;
          hold_d  = 1'b1;
        end else begin
          dly_d = dly_q - 1'b1;
        end
      end
      SQ_SETTLE: begin
        if (setl_q == '0) begin
          state_d = SQ_SCAN;
          slot_d  = '0;
          ch_d    = '0;
        end else begin
          setl_d = setl_q - 1'b1;
        end
      end
      SQ_SCAN: begin
        if (!stall) begin
          if (slot_q == LAST_SLOT) begin
            slot_d = '0;
            if (ch_q == LAST_CH) begin
              state_d = SQ_DRAIN;
              hold_d  = 1'b0;
              ch_d    = '0;
            end else begin
              ch_d = ch_q + 1'b1;
            end
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end
      end
      SQ_DRAIN: begin
        if (!buf_pending) begin
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      dly_q   <= '0;
      setl_q  <= '0;
      slot_q  <= '0;
      ch_q    <= '0;
      hold_q  <= 1'b0;
    end else if (run_en) begin
      state_q <= state_d;
      dly_q   <= dly_d;
      setl_q  <= setl_d;
      slot_q  <= slot_d;
      ch_q    <= ch_d;
      hold_q  <= hold_d;
    end
  end

  assign hold     = hold_q;
  assign mux_addr = ch_q;
  assign busy     = (state_q != SQ_IDLE);

  // R3
  hold_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> ($past(state_q) == SQ_DELAY));

  // R4
  mux_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SCAN && $past(state_q) == SQ_SCAN)
      |-> (ch_q == $past(ch_q) || ch_q == $past(ch_q) + 1'b1));

  // R10
  hold_release_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> (ch_q == '0));

  // R11
  free_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SETTLE && $past(state_q) == SQ_IDLE) |-> !hold_q);

endmodule

// File: rtl/rs_sample_buf.sv
module rs_sample_buf
  import rs_pkg::*;
#(
  parameter int N_CHIPS = 3,
  parameter int N_CH    = 32,
  parameter int ADC_W   = 12,
  localparam int LANES  = 2 * N_CHIPS,
  localparam int CHIP_W = bits_for(N_CHIPS),
  localparam int LANE_W = CHIP_W + 1,
  localparam int CH_W   = bits_for(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic [CH_W-1:0]        chan_in,
  input  logic [LANES*ADC_W-1:0] adc_words,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [CHIP_W-1:0]      out_chip,
  output logic [CH_W-1:0]        out_chan,
  output logic                   out_lowgain,
  output logic [ADC_W-1:0]       out_data,
  output logic                   pending
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [LANES-1:0][ADC_W-1:0] lane_w;
  logic [CH_W-1:0]             chan_q;
  logic [LANE_W-1:0]           idx_q, idx_d;
  logic                        pend_q, pend_d;
  logic                        hs;

  // One capture register per ADC lane, loaded together
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADC_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (capture) begin
        word_q <= adc_words[k*ADC_W +: ADC_W];
      end
    end
    assign lane_w[k] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (capture) begin
      chan_q <= chan_in;
    end
  end

  assign hs = pend_q && out_ready;

  always_comb begin
    pend_d = pend_q;
    idx_d  = idx_q;
    if (capture) begin
      pend_d = 1'b1;
      idx_d  = '0;
    end else if (hs) begin
      if (idx_q == LAST_LANE) begin
        pend_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else if (capture || hs) begin
      pend_q <= pend_d;
      idx_q  <= idx_d;
    end
  end

  assign out_valid   = pend_q;
  assign pending     = pend_q;
  assign out_chip    = CHIP_W'(idx_q >> 1);
  assign out_lowgain = idx_q[0];
  assign out_chan    = chan_q;
  assign out_data    = lane_w[idx_q];

  // R7
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(idx_q) && $stable(chan_q)));

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer
  import rs_pkg::*;
#(
  parameter int N_CHIPS       = 3,
  parameter int N_CH          = 32,
  parameter int ADC_W         = 12,
  parameter int SLOT_CYCLES   = 10,
  parameter int SETTLE_CYCLES = 4,
  parameter int DLY_W         = 8,
  localparam int LANES  = 2 * N_CHIPS,
  localparam int CHIP_W = bits_for(N_CHIPS),
  localparam int CH_W   = bits_for(N_CH),
  localparam int SLOT_W = bits_for(SLOT_CYCLES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   free_run,
  input  logic [N_CHIPS-1:0]     trig_in,
  input  logic [DLY_W-1:0]       hold_dly,
  input  logic [SLOT_W-1:0]      samp_pt,
  input  logic [LANES*ADC_W-1:0] adc_bus,
  output logic                   hold,
  output logic [CH_W-1:0]        mux_addr,
  output logic                   busy,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [CHIP_W-1:0]      out_chip,
  output logic [CH_W-1:0]        out_chan,
  output logic                   out_lowgain,
  output logic [ADC_W-1:0]       out_data
);

  logic srst_n;
  logic start_req;
  logic capture;
  logic pending;

  rs_reset_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rs_start_gate #(.N_CHIPS(N_CHIPS)) u_gate (
    .trig_lines (trig_in),
    .free_sel   (free_run),
    .start_req  (start_req)
  );

  rs_sequencer #(
    .N_CH          (N_CH),
    .SLOT_CYCLES   (SLOT_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .DLY_W         (DLY_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .start_req   (start_req),
    .free_sel    (free_run),
    .hold_dly    (hold_dly),
    .samp_pt     (samp_pt),
    .buf_pending (pending),
    .hold        (hold),
    .mux_addr    (mux_addr),
    .busy        (busy),
    .capture     (capture)
  );

  rs_sample_buf #(
    .N_CHIPS (N_CHIPS),
    .N_CH    (N_CH),
    .ADC_W   (ADC_W)
  ) u_buf (
    .clk         (clk),
    .rst_n       (srst_n),
    .capture     (capture),
    .chan_in     (mux_addr),
    .adc_words   (adc_bus),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_chip    (out_chip),
    .out_chan    (out_chan),
    .out_lowgain (out_lowgain),
    .out_data    (out_data),
    .pending     (pending)
  );

  // R9
  valid_within_busy_chk: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> busy);

endmodule

// File: tb/tb_readout_sequencer.sv
module tb_readout_sequencer;

  localparam int L     = 10;
  localparam int S     = 4;
  localparam int NCH   = 32;
  localparam int LANES = 6;
  localparam int SCANW = NCH * LANES;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        free_run;
  logic [2:0]  trig_in;
  logic [7:0]  hold_dly;
  logic [3:0]  samp_pt;
  logic [71:0] adc_bus;
  logic        hold;
  logic [4:0]  mux_addr;
  logic        busy;
  logic        out_valid;
  logic        out_ready;
  logic [1:0]  out_chip;
  logic [4:0]  out_chan;
  logic        out_lowgain;
  logic [11:0] out_data;

  always #4 clk = ~clk;

  readout_sequencer dut (
    .clk(clk), .rst_n(rst_n), .free_run(free_run), .trig_in(trig_in),
    .hold_dly(hold_dly), .samp_pt(samp_pt), .adc_bus(adc_bus),
    .hold(hold), .mux_addr(mux_addr), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_chip(out_chip), .out_chan(out_chan),
    .out_lowgain(out_lowgain), .out_data(out_data)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit timed = 0, strm = 0, bp_en = 0, adc_mux = 0;
  int hs_cnt = 0, hold_hi = 0, hold_rises = 0;
  bit hold_prev = 0;
  bit stall_seen = 0;
  int saved_chan = 0, saved_chip = 0, saved_data = 0;
  // reference model state
  bit have = 0;
  int T = 0, D = 0, P = 0, B = 0, end_e = 0;

  function automatic int fdat(input int x, input int k);
    return (x * 37 + k * 411 + 5) % 4096;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Reference model: accepts a trigger on an edge after the previous scan ended
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (timed && !free_run && trig_in != 3'b000 && cyc > end_e) begin
      have  = 1;
      T     = cyc;
      D     = hold_dly;
      P     = (samp_pt > L - 1) ? L - 1 : samp_pt;
      B     = T + D + 1 + S;
      end_e = (B + 32 * L + 1 > B + 31 * L + P + 8) ? B + 32 * L + 1 : B + 31 * L + P + 8;
    end
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold && !hold_prev) hold_rises++;
      if (!hold && hold_prev) chk("R10 mux after hold release", mux_addr, 0);
      hold_prev = hold;
      if (hold) hold_hi++;
      if (timed) begin
        int e, r, n, i;
        bit eb, eh, ev;
        int em;
        e  = cyc;
        eb = have && e >= T && e < end_e;
        eh = have && e >= T + D + 1 && e < B + 32 * L;
        em = (have && e >= B && e < B + 32 * L) ? (e - B) / L : 0;
        r  = e - (B + P + 1);
        ev = have && r >= 0 && r / L < NCH && r % L < LANES;
        chk("R9 busy", busy, eb);
        chk("R3 hold", hold, eh);
        chk("R4 mux_addr", mux_addr, em);
        chk("R5 out_valid", out_valid, ev);
        if (ev) begin
          n = r / L;
          i = r % L;
          chk("R6 chip", out_chip, i / 2);
          chk("R6 chan", out_chan, n);
          chk("R6 gain", out_lowgain, i % 2);
          chk("R5 data", out_data, fdat(B + n * L + P, i));
        end
      end
      if (strm) begin
        if (stall_seen) begin
          chk("R7 valid held", out_valid, 1);
          chk("R7 chan held", out_chan, saved_chan);
          chk("R7 chip held", out_chip, saved_chip);
          chk("R7 data held", out_data, saved_data);
        end
        stall_seen = out_valid && !out_ready;
        saved_chan = out_chan;
        saved_chip = out_chip;
        saved_data = out_data;
        if (out_valid && out_ready) begin
          int k, ln;
          k  = hs_cnt % SCANW;
          ln = k % LANES;
          chk("R6 chip", out_chip, ln / 2);
          chk("R6 chan", out_chan, k / LANES);
          chk("R6 gain", out_lowgain, ln % 2);
          chk("R5 data", out_data, 12'h800 | ((k / LANES) << 3) | ln);
          hs_cnt++;
        end
      end
    end
  end

  // ADC lanes: cycle-coded values, or values coded by mux address and lane
  initial begin
    adc_bus = '0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < LANES; k++) begin
        if (adc_mux)
          adc_bus[k*12 +: 12] <= 12'(12'h800 | (mux_addr << 3) | k);
        else
          adc_bus[k*12 +: 12] <= 12'(fdat(cyc, k));
      end
    end
  end

  // Downstream ready, random when backpressure is enabled
  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= bp_en ? lfsr[0] : 1'b1;
    end
  end

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic scan(input int line, input int d, input int sp, input bit extra);
    int rises0;
    @(negedge clk);
    hold_dly = 8'(d);
    samp_pt  = 4'(sp);
    rises0   = hold_rises;
    trig_in  = 3'(1 << line);
    @(negedge clk);
    trig_in = 3'b000;
    chk("R2 busy after trigger line", busy, 1);
    if (extra) begin
      // R8: triggers during the scan must be ignored
      repeat (50) @(negedge clk);
      trig_in = 3'b111;
      @(negedge clk);
      trig_in = 3'b000;
      repeat (100) @(negedge clk);
      trig_in = 3'b010;
      @(negedge clk);
      trig_in = 3'b000;
    end
    wait_idle();
    chk("R8 single hold pulse per scan", hold_rises - rises0, 1);
  endtask

  initial begin
    rst_n    = 1'b0;
    free_run = 1'b0;
    trig_in  = 3'b000;
    hold_dly = 8'd6;
    samp_pt  = 4'd3;
    repeat (3) @(negedge clk);
    chk("R1 hold in reset", hold, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 mux in reset", mux_addr, 0);
    chk("R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {hold, busy, out_valid}, 0);
    timed = 1;
    scan(0, 6, 3, 0);    // R2 chip 0 line, R3 6-step delay
    scan(1, 0, 9, 1);    // R8 extra triggers, last-cycle sampling point
    scan(2, 20, 15, 0);  // R12 out-of-range sampling point clamps
    scan(1, 3, 0, 0);    // R5 earliest sampling point
    timed = 0;

    // R7: random backpressure, slot waits at the sampling point
    adc_mux = 1;
    samp_pt = 4'd5;
    hs_cnt  = 0;
    strm    = 1;
    bp_en   = 1;
    @(negedge clk);
    trig_in = 3'b001;
    @(negedge clk);
    trig_in = 3'b000;
    wait_idle();
    chk("R7 all words delivered under backpressure", hs_cnt, SCANW);
    bp_en = 0;

    // R11: free-running scans without trigger and without hold
    hs_cnt  = 0;
    hold_hi = 0;
    free_run = 1'b1;
    while (hs_cnt < 2 * SCANW) @(negedge clk);
    chk("R11 no hold in free-running mode", hold_hi, 0);
    chk("R11 two scans without trigger", (hs_cnt >= 2 * SCANW) ? 1 : 0, 1);
    free_run = 1'b0;
    wait_idle();
    chk("R11 idle after leaving free-running mode", busy, 0);
    strm = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule